// File: doc/BRIEF.md
# Periodic Reload Down-Counter Timer

This block is a system tick timer. A 24-bit counter counts down by one on each qualified tick. When the count goes from 1 to 0 the block sets a sticky count flag and, if interrupts are allowed, sends a one-cycle interrupt pulse. On the next tick after that, the counter loads the reload value again. The result is a free-running periodic event every reload+1 ticks. For a period of T ticks, software writes T-1 into the reload register.

The tick comes from one of two places, chosen by a source bit in the control register. One is the bus clock itself, with one tick every cycle. The other is a slow path whose 2-bit selector picks one of three strobes: the bus clock divided by eight through an internal prescaler, a low-speed internal strobe, or a low-speed external strobe. The slow strobes come in already qualified in the bus clock domain, so this block generates no clock.

Software accesses the block through a small word-addressed register port:

| Address | Register | Contents |
|---|---|---|
| 0 | Control | enable (bit 0), interrupt enable (bit 1), bus-clock source (bit 2), slow selector (bits 5:4), count flag (bit 16, read-only) |
| 1 | Reload | 24-bit reload value |
| 2 | Current | counter value; any write zeroes it |

Top module: `tick_timer`

## Requirements
- R1: After a synchronous reset, the block is in this state: control reads 0, reload reads 0, current reads 0, and `irq` is low.
- R2: When enable (control bit 0) and the bus-clock source (control bit 2) are both set, the counter changes on every cycle. Starting from 0 it loads the reload value R, then steps down by one per cycle to 0, then loads R again. The period is R+1 cycles.
- R3: With a reload value of 0, the counter stays at 0 and no interrupt is raised.
- R4: A write of any data to the current register (address 1 is reload, address 2 is current) sets the counter to 0 at that edge. The next tick then loads the reload value.
- R5: The count flag (control bit 16) sets when the counter goes from 1 to 0. A read of the control register clears it, but a new set in the same cycle wins over the clear.
- R6: `irq` is a one-cycle pulse on the cycle the counter becomes 0 from 1. It fires only when interrupt enable (control bit 1) is set.
- R7: When enable is clear, the counter holds its value.
- R8: When the source bit is clear, the selector (control bits 5:4) picks the tick as follows: 0 is the divide-by-8 strobe, 1 is `slow_int_tick`, 2 is `slow_ext_tick`, and 3 acts as 0. Strobes that are not selected have no effect.
- R9: In divide-by-8 mode there is one tick every eight bus cycles, so the interrupt period is 8*(R+1) cycles.
- R10: The reload register keeps only the low 24 bits of a write. Upper data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading control clears the count flag) |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| slow_int_tick | input | 1 | Low-speed internal tick strobe, one bus cycle wide |
| slow_ext_tick | input | 1 | Low-speed external tick strobe, one bus cycle wide |
| irq | output | 1 | Interrupt pulse at the 1-to-0 step |

## Verification
The bound checker checks several properties on every cycle:
- A stopped counter never moves unless it is zeroed.
- A current-register write leaves the counter at 0 on the next cycle.
- The counter never changes by more than one step, except when it reloads from zero.
- Every interrupt pulse follows a count of 1, lands on a count of 0, had interrupt enable set the cycle before, and is seen together with the set flag.

The bench scenarios cover what no single-cycle property can show:
- exact counter values a given number of cycles after start;
- the R+1 and 8*(R+1) periods;
- the selector's code mapping, including the code 3 alias;
- the flag being cleared by a read;
- a reload of 0 staying silent;
- 24-bit truncation of the reload value.

// File: rtl/tick_timer_pkg.sv
// Shared definitions for the tick timer: register addresses, control
// field positions and the slow tick source encoding.
package tick_timer_pkg;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_CUR    = 2'd2;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_BUS_BIT  = 2;
    localparam int CTRL_SEL_LSB  = 4;
    localparam int CTRL_FLAG_BIT = 16;

    typedef enum logic [1:0] {
        SRC_DIV8 = 2'd0,
        SRC_INT  = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_ALT  = 2'd3
    } slow_src_e;

endpackage

// File: rtl/tick_src_sel.sv
// Tick source selection.
// Produces the counting enable strobe, either every bus cycle or from one of
// three slow strobes: the bus clock divided by 2**PRE_W through a free-running
// prescaler, or one of two externally qualified strobes.
// Assumes the slow strobes are already synchronous and one cycle wide.
module tick_src_sel
    import tick_timer_pkg::*;
#(
    parameter int PRE_W = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      use_bus,
    input  slow_src_e slow_sel,
    input  logic      slow_int_tick,
    input  logic      slow_ext_tick,
    output logic      tick
);

    logic [PRE_W-1:0] pre_q;
    logic             pre_strobe;

    // Free-running prescaler for the divided bus clock path.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + PRE_W'(1);
    end

    assign pre_strobe = &pre_q;

    // Pick the active tick source; unlisted codes fall back to the divider.
    always_comb begin
        if (use_bus) begin
            tick = 1'b1;
        end else begin
            case (slow_sel)
                SRC_INT: tick = slow_int_tick;
                SRC_EXT: tick = slow_ext_tick;
                default: tick = pre_strobe;
            endcase
        end
    end

endmodule

// File: rtl/tick_down_counter.sv
// Reloading down-counter.
// On each enabled tick the counter steps down by one. From zero it loads the
// reload value, so a reload of 0 parks it at zero. A zero request wins over
// a tick. 'wrap' marks the tick that takes the count from 1 to 0.
module tick_down_counter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         zero_req,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    logic [W-1:0] cnt_q;
    logic         step;

    assign step = run & tick;
    assign wrap = step & ~zero_req & (cnt_q == W'(1));
    assign cnt  = cnt_q;

    // Counter update: zero request, then reload at zero, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (zero_req) begin
            cnt_q <= '0;
        end else if (step) begin
            if (cnt_q == '0) cnt_q <= reload;
            else             cnt_q <= cnt_q - W'(1);
        end
    end

endmodule

// File: rtl/tick_ctrl_regs.sv
// Register port of the tick timer.
// Holds the control bits, the reload value and the sticky count flag, decodes
// writes and reads, and registers the interrupt pulse. Assumes single-cycle
// access strobes; read data is combinational from the address.
module tick_ctrl_regs
    import tick_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              wrap,
    output logic              run,
    output logic              ie,
    output logic              use_bus,
    output slow_src_e         slow_sel,
    output logic [CNT_W-1:0]  reload,
    output logic              zero_req,
    output logic              flag,
    output logic              irq
);

    logic             en_q, ie_q, bus_q, flag_q, irq_q;
    slow_src_e        sel_q;
    logic [CNT_W-1:0] reload_q;
    logic             ctrl_wr, reload_wr, ctrl_rd;
    logic             unused_wdata_bits;

    assign ctrl_wr   = bus_wr & (bus_addr == ADDR_CTRL);
    assign reload_wr = bus_wr & (bus_addr == ADDR_RELOAD);
    assign zero_req  = bus_wr & (bus_addr == ADDR_CUR);
    assign ctrl_rd   = bus_rd & (bus_addr == ADDR_CTRL);
    assign unused_wdata_bits = ^bus_wdata[DATA_W-1:CNT_W];

    // Control fields written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ie_q  <= 1'b0;
            bus_q <= 1'b0;
            sel_q <= SRC_DIV8;
        end else if (ctrl_wr) begin
            en_q  <= bus_wdata[CTRL_EN_BIT];
            ie_q  <= bus_wdata[CTRL_IE_BIT];
            bus_q <= bus_wdata[CTRL_BUS_BIT];
            sel_q <= slow_src_e'(bus_wdata[CTRL_SEL_LSB +: 2]);
        end
    end

    // Reload value keeps only the counter width.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '0;
        else if (reload_wr) reload_q <= bus_wdata[CNT_W-1:0];
    end

    // Sticky count flag: set on wrap, cleared by a control read, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (wrap)    flag_q <= 1'b1;
        else if (ctrl_rd) flag_q <= 1'b0;
    end

    // One-cycle interrupt pulse on wrap when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= wrap & ie_q;
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTRL_EN_BIT]       = en_q;
                bus_rdata[CTRL_IE_BIT]       = ie_q;
                bus_rdata[CTRL_BUS_BIT]      = bus_q;
                bus_rdata[CTRL_SEL_LSB +: 2] = sel_q;
                bus_rdata[CTRL_FLAG_BIT]     = flag_q;
            end
            ADDR_RELOAD: bus_rdata[CNT_W-1:0] = reload_q;
            ADDR_CUR:    bus_rdata[CNT_W-1:0] = cnt;
            default:     bus_rdata = '0;
        endcase
    end

    assign run      = en_q;
    assign ie       = ie_q;
    assign use_bus  = bus_q;
    assign slow_sel = sel_q;
    assign reload   = reload_q;
    assign flag     = flag_q;
    assign irq      = irq_q;

endmodule

// File: rtl/tick_timer.sv
// Periodic reload down-counter timer, top level.
// Connects the register port, the tick source selector and the counter.
// Assumes one bus clock domain; the slow strobes are pre-qualified.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int PRE_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              slow_int_tick,
    input  logic              slow_ext_tick,
    output logic              irq
);

    logic             run, ie, use_bus, zero_req, flag, wrap, tick;
    slow_src_e        slow_sel;
    logic [CNT_W-1:0] reload, cnt;

    tick_ctrl_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt), .wrap(wrap),
        .run(run), .ie(ie), .use_bus(use_bus), .slow_sel(slow_sel),
        .reload(reload), .zero_req(zero_req), .flag(flag), .irq(irq)
    );

    tick_src_sel #(.PRE_W(PRE_W)) u_src (
        .clk(clk), .rst_n(rst_n),
        .use_bus(use_bus), .slow_sel(slow_sel),
        .slow_int_tick(slow_int_tick), .slow_ext_tick(slow_ext_tick),
        .tick(tick)
    );

    tick_down_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .run(run), .tick(tick), .zero_req(zero_req), .reload(reload),
        .cnt(cnt), .wrap(wrap)
    );

endmodule

// File: rtl/tick_timer_chk.sv
// Property checker for the tick timer, bound to every instance of the top.
// Observes the counter, the control state and the interrupt output.
module tick_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             ie,
    input logic             zero_req,
    input logic [CNT_W-1:0] cnt,
    input logic             flag,
    input logic             irq
);

    p_hold_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !zero_req) |=> $stable(cnt));

    p_zero_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_req |=> (cnt == '0));

    p_step_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !zero_req) |=> (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1)));

    p_irq_needs_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ie));

    p_irq_at_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(cnt) == CNT_W'(1) && cnt == '0));

    p_flag_with_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .ie(ie), .zero_req(zero_req),
    .cnt(cnt), .flag(flag), .irq(irq)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        slow_int_tick = 1'b0, slow_ext_tick = 1'b0;
    logic        irq;

    int tests = 0;
    int fails = 0;

    // Vector: {reload[24], cycles after start[8], expected count[24]} in bus mode
    localparam logic [55:0] VEC [8] = '{
        {24'd10, 8'd1,  24'd10},
        {24'd10, 8'd4,  24'd7},
        {24'd10, 8'd11, 24'd0},
        {24'd10, 8'd12, 24'd10},
        {24'd5,  8'd6,  24'd0},
        {24'd5,  8'd9,  24'd3},
        {24'd0,  8'd5,  24'd0},
        {24'hFFFFFF, 8'd3, 24'hFFFFFD}
    };

    tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .slow_int_tick(slow_int_tick), .slow_ext_tick(slow_ext_tick), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_clear(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_int();
        @(negedge clk); slow_int_tick = 1'b1;
        @(negedge clk); slow_int_tick = 1'b0;
    endtask

    task automatic pulse_ext();
        @(negedge clk); slow_ext_tick = 1'b1;
        @(negedge clk); slow_ext_tick = 1'b0;
    endtask

    task automatic irq_gap(output int gap);
        int n;
        n = 0;
        @(negedge clk);
        while (!irq && n < 1000) begin @(negedge clk); n++; end
        gap = 0;
        do begin @(negedge clk); gap++; end while (!irq && gap < 1000);
    endtask

    initial begin
        #(CLK_P * 150000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, v0;
        int gap, cnt_irq;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(2'd0, v); check("R1 ctrl", v, 32'h0);
        peek(2'd1, v); check("R1 reload", v, 32'h0);
        peek(2'd2, v); check("R1 current", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 vector table, bus clock mode
        foreach (VEC[i]) begin
            wr(2'd0, 32'h0);
            wr(2'd1, {8'h0, VEC[i][55:32]});
            wr(2'd2, 32'h1234);
            wr(2'd0, 32'h5);
            repeat (int'(VEC[i][31:24])) @(posedge clk);
            @(negedge clk);
            peek(2'd2, v);
            check("R2/R3 count", v, {8'h0, VEC[i][23:0]});
            check("R6 no irq without ie", {31'b0, irq}, 32'h0);
        end

        // R5/R6 flag and pulse, R=3, bus mode, ie set
        wr(2'd0, 32'h0); wr(2'd1, 32'd3); wr(2'd2, 32'h0);
        wr(2'd0, 32'h7);
        repeat (3) @(posedge clk); @(negedge clk);
        check("R6 no irq at count 1", {31'b0, irq}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R6 irq at wrap", {31'b0, irq}, 32'h1);
        peek(2'd0, v); check("R5 flag set", {31'b0, v[16]}, 32'h1);
        rd_clear(2'd0, v); check("R5 flag seen on read", {31'b0, v[16]}, 32'h1);
        peek(2'd0, v); check("R5 flag cleared by read", {31'b0, v[16]}, 32'h0);
        irq_gap(gap); check("R2 period R+1", gap, 32'd4);

        // R9 divide-by-8, selector 0 and alias 3
        wr(2'd0, 32'h3);
        irq_gap(gap); check("R9 div8 period", gap, 32'd32);
        wr(2'd0, 32'h33);
        irq_gap(gap); check("R8 code 3 as div8", gap, 32'd32);

        // R8 slow internal / external strobes
        wr(2'd0, 32'h0); wr(2'd1, 32'd5); wr(2'd2, 32'h0);
        wr(2'd0, 32'h11);
        repeat (12) @(negedge clk);
        peek(2'd2, v); check("R8 int idle no count", v, 32'd0);
        pulse_int(); pulse_int(); pulse_int();
        peek(2'd2, v); check("R8 int strobe counts", v, 32'd3);
        pulse_ext(); pulse_ext();
        peek(2'd2, v); check("R8 ext ignored on code 1", v, 32'd3);
        wr(2'd0, 32'h21);
        pulse_int();
        peek(2'd2, v); check("R8 int ignored on code 2", v, 32'd3);
        pulse_ext(); pulse_ext();
        peek(2'd2, v); check("R8 ext strobe counts", v, 32'd1);

        // R4 current write zeroes while running, then reloads
        wr(2'd0, 32'h0); wr(2'd1, 32'd100); wr(2'd0, 32'h5);
        repeat (20) @(negedge clk);
        wr(2'd2, 32'hABCD);
        peek(2'd2, v); check("R4 zeroed by write", v, 32'd0);
        @(posedge clk); @(negedge clk);
        peek(2'd2, v); check("R4 reload after zero", v, 32'd100);

        // R7 enable clear holds count
        repeat (5) @(negedge clk);
        wr(2'd0, 32'h4);
        peek(2'd2, v0);
        repeat (10) @(negedge clk);
        peek(2'd2, v); check("R7 hold when disabled", v, v0);

        // R3 reload 0 never interrupts
        wr(2'd1, 32'd0); wr(2'd2, 32'd0); wr(2'd0, 32'h7);
        cnt_irq = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (irq) cnt_irq++;
        end
        check("R3 no irq with reload 0", cnt_irq, 32'd0);
        peek(2'd2, v); check("R3 count stays 0", v, 32'd0);

        // R10 reload width
        wr(2'd1, 32'hFFFFFFFF);
        peek(2'd1, v); check("R10 reload truncated", v, 32'h00FFFFFF);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule